// File: doc/BRIEF.md
# I2C Target with Deglitched Inputs

This block is the target (slave) end of a two-wire serial bus. Both bus lines pass through a synchronizer chain and a glitch filter before any logic sees them. A filter only changes its output after its synchronized input has disagreed with that output for a set number of consecutive clock cycles. With the filtered lines the block finds START and STOP conditions and reads the first byte of every transfer as a 7-bit address, most significant bit first, followed by a direction bit.

The address is compared against a programmed own address and, when that option is enabled, against the general call address. On a hit the block acknowledges the byte and gives a one-cycle interrupt pulse.

In a write transfer it presents each received byte to the host logic and acknowledges it. In a read transfer it requests a byte from the host logic and shifts that byte out on the data line. After each byte it records whether the controller answered with an acknowledge or a not-acknowledge. The data line is controlled only through an open-drain pull-down enable.

Top module: `i2c_target`

## Requirements
- R1: A pulse on the SCL or SDA input lasting fewer than 3 clock cycles (FILT_LEN) has no effect on the transfer. A pulse lasting 3 cycles or more is taken as a real level change.
- R2: A START condition (SDA falling while SCL is high) is recognised in any state. A repeated START in the middle of a data byte drops that byte, and the block receives a new address byte.
- R3: When the 7 address bits equal `own_addr`, with either direction bit, the block pulls SDA low during the ninth clock (`sda_oe`=1), pulses `irq` high for exactly one cycle and clears `gc_hit`.
- R4: Address 0000000 with direction bit 0 is a general call. It is acknowledged, pulses `irq` and sets `gc_hit`=1. Address 0000000 with direction bit 1 gets no acknowledge and no `irq`.
- R5: Any other address gets no acknowledge and no `irq`. Bytes that follow it are neither acknowledged nor reported until the next START.
- R6: In a write transfer (direction 0), each received byte (MSB first) appears on `rx_data` with a one-cycle `rx_valid` pulse, and the block acknowledges it.
- R7: In a read transfer (direction 1), `tx_data` is loaded at the SCL falling edge that ends the acknowledge clock, and `tx_req` pulses once per load. The byte is driven MSB first, with `sda_oe`=1 for a 0 bit. `sda_oe` never changes while SCL is high.
- R8: At the rising SCL edge of each ninth clock of a read, `mst_ack_valid` pulses and `mst_nack` takes the SDA level (1 = not-acknowledge). After an acknowledge the next byte is loaded. After a not-acknowledge, SDA stays released and nothing more is loaded until a START or STOP.
- R9: A STOP condition (SDA rising while SCL is high) returns the block to idle with SDA released.
- R10: After reset, `sda_oe`, `irq`, `rx_valid`, `tx_req` and `mst_ack_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data from the bus |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release SDA |
| own_addr | input | 7 | Programmed own address |
| irq | output | 1 | One-cycle pulse on an address hit |
| gc_hit | output | 1 | Last hit was a general call |
| xfer_rd | output | 1 | Current matched transfer is a read |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| tx_data | input | 8 | Next byte to transmit |
| tx_req | output | 1 | One-cycle pulse when tx_data is taken |
| mst_ack_valid | output | 1 | One-cycle pulse when the controller's acknowledge is sampled |
| mst_nack | output | 1 | Last sampled acknowledge was a not-acknowledge |

## Verification
A level change on a pin reaches the core after the two synchronizer stages plus three filter cycles. The edge detector adds one more register, and the registered outputs (`sda_oe`, `irq`, `rx_valid`, `tx_req`) respond one cycle after that, about seven cycles in all. The bench keeps every bus phase at least 12 cycles long. It reads the line level only at the end of a 24-cycle SCL high phase, when any drive change from the preceding low phase has long settled. Pulse outputs are counted on every falling clock edge, so a check compares totals and does not depend on the exact cycle of a pulse.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } i2ct_state_e;

   localparam logic [6:0] GC_ADDR = 7'b0000000;
endpackage

// File: rtl/i2ct_deglitch.sv
module i2ct_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic filt_o
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end
   assign sy = sync_q[SYNC_STAGES-1];

   if (FILT_LEN < 2) begin : g_nofilt
      assign filt_o = sy;
   end else begin : g_filt
      logic [CW-1:0] cnt;
      logic          out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= '0;
            out_q <= 1'b1;
         end else if (sy != out_q) begin
            if (cnt == CW'(FILT_LEN - 1)) begin
               out_q <= sy;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
      assign filt_o = out_q;

      // R1
      filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sy == out_q) |=> $stable(out_q));
      // R1
      filt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(out_q) |-> (out_q == $past(sy)));
   end
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit GC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic [DATA_W-2:0] own_addr,
   output logic              sda_oe,
   output logic              irq,
   output logic              gc_hit,
   output logic              xfer_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_req,
   output logic              mst_ack_valid,
   output logic              mst_nack
);
   localparam int CW = $clog2(DATA_W + 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("DATA_W must be 8 for 7-bit addressing");
   end

   i2ct_state_e       st;
   logic              scl_q, sda_q, matched;
   logic [CW-1:0]     bcnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] nxt;
   logic              start_det, stop_det, rise, fall;
   logic              hit_own, hit_gc;

   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
   assign rise      = scl_f & ~scl_q;
   assign fall      = ~scl_f & scl_q;
   assign nxt       = {sh[DATA_W-2:0], sda_f};
   assign hit_own   = (nxt[DATA_W-1:1] == own_addr);
   assign hit_gc    = GC_EN && (nxt[DATA_W-1:1] == GC_ADDR) && !nxt[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         scl_q         <= 1'b1;
         sda_q         <= 1'b1;
         matched       <= 1'b0;
         bcnt          <= '0;
         sh            <= '0;
         sda_oe        <= 1'b0;
         irq           <= 1'b0;
         gc_hit        <= 1'b0;
         xfer_rd       <= 1'b0;
         rx_data       <= '0;
         rx_valid      <= 1'b0;
         tx_req        <= 1'b0;
         mst_ack_valid <= 1'b0;
         mst_nack      <= 1'b0;
      end else begin
         scl_q         <= scl_f;
         sda_q         <= sda_f;
         irq           <= 1'b0;
         rx_valid      <= 1'b0;
         tx_req        <= 1'b0;
         mst_ack_valid <= 1'b0;
         if (start_det) begin
            st      <= ST_ADDR;
            bcnt    <= '0;
            sda_oe  <= 1'b0;
            xfer_rd <= 1'b0;
         end else if (stop_det) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            xfer_rd <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (rise) begin
                     sh   <= nxt;
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == CW'(DATA_W - 1)) begin
                        matched <= hit_own | hit_gc;
                        if (hit_own | hit_gc) begin
                           irq     <= 1'b1;
                           gc_hit  <= hit_gc & ~hit_own;
                           xfer_rd <= nxt[0];
                        end
                     end
                  end else if (fall && bcnt == CW'(DATA_W)) begin
                     if (matched) begin
                        sda_oe <= 1'b1;
                        st     <= ST_AACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_AACK, ST_TACK: begin
                  if (st == ST_TACK && rise) begin
                     mst_ack_valid <= 1'b1;
                     mst_nack      <= sda_f;
                     if (sda_f) st <= ST_IDLE;
                  end else if (fall) begin
                     bcnt <= '0;
                     if (xfer_rd) begin
                        sh     <= tx_data;
                        tx_req <= 1'b1;
                        sda_oe <= ~tx_data[DATA_W-1];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (rise) begin
                     sh   <= nxt;
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == CW'(DATA_W - 1)) begin
                        rx_data  <= nxt;
                        rx_valid <= 1'b1;
                     end
                  end else if (fall && bcnt == CW'(DATA_W)) begin
                     sda_oe <= 1'b1;
                     st     <= ST_RACK;
                  end
               end
               ST_RACK: begin
                  if (fall) begin
                     sda_oe <= 1'b0;
                     bcnt   <= '0;
                     st     <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (rise) begin
                     bcnt <= bcnt + 1'b1;
                  end else if (fall) begin
                     if (bcnt == CW'(DATA_W)) begin
                        sda_oe <= 1'b0;
                        st     <= ST_TACK;
                     end else begin
                        sh     <= {sh[DATA_W-2:0], 1'b0};
                        sda_oe <= ~sh[DATA_W-2];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R7
   oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_f);
   // R3
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R7
   txreq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> xfer_rd);
   // R8
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_ack_valid && mst_nack) |=> !sda_oe);
   // R9
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && st == ST_IDLE));
   // R6
   rx_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && tx_req));
endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter bit GC_EN       = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [6:0] own_addr,
   output logic       irq,
   output logic       gc_hit,
   output logic       xfer_rd,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   input  logic [7:0] tx_data,
   output logic       tx_req,
   output logic       mst_ack_valid,
   output logic       mst_nack
);
   logic scl_f, sda_f;

   i2ct_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .filt_o(scl_f));
   i2ct_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .filt_o(sda_f));

   i2ct_engine #(.DATA_W(8), .GC_EN(GC_EN)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .own_addr(own_addr), .sda_oe(sda_oe), .irq(irq), .gc_hit(gc_hit),
      .xfer_rd(xfer_rd), .rx_data(rx_data), .rx_valid(rx_valid),
      .tx_data(tx_data), .tx_req(tx_req), .mst_ack_valid(mst_ack_valid),
      .mst_nack(mst_nack));
endmodule

// File: tb/sim_i2c_target.sv
module sim_i2c_target;
   localparam int Q = 12;
   localparam int H = 24;
   localparam logic [6:0] OWN = 7'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_oe, irq, gc_hit, xfer_rd, rx_valid, tx_req, mst_ack_valid, mst_nack;
   logic [7:0] rx_data;
   logic [7:0] tx_data = 8'hA5;
   logic       sda_line;

   int tests = 0, fails = 0;
   int irq_n = 0, rxv_n = 0, txr_n = 0, mav_n = 0, viol = 0;
   logic [7:0] rx_log [0:15];
   logic       poe = 1'b0, pscl = 1'b1;
   bit         done = 1'b0;

   always #10 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .own_addr(OWN), .irq(irq), .gc_hit(gc_hit), .xfer_rd(xfer_rd),
      .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data), .tx_req(tx_req),
      .mst_ack_valid(mst_ack_valid), .mst_nack(mst_nack));

   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) irq_n++;
         if (rx_valid) begin
            rx_log[rxv_n[3:0]] = rx_data;
            rxv_n++;
         end
         if (tx_req) begin
            txr_n++;
            tx_data = tx_data + 8'h13;
         end
         if (mst_ack_valid) mav_n++;
         if (sda_oe != poe && scl_m && pscl) viol++;
      end
      poe  = sda_oe;
      pscl = scl_m;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
   endtask

   task automatic bstop();
      wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
   endtask

   // gsel: 0 none, 1 SCL pulse in low phase, 2 SDA low pulse in high phase
   task automatic sbit(input logic b, input int gsel, input int glen, output logic lb);
      wt(Q); sda_m = b;
      if (gsel == 1) begin
         wt(2); scl_m = 1'b1; wt(glen); scl_m = 1'b0;
      end
      wt(Q); scl_m = 1'b1;
      if (gsel == 2) begin
         wt(8); sda_m = 1'b0; wt(glen); sda_m = b; wt(H - 8 - glen);
      end else begin
         wt(H);
      end
      lb = sda_line;
      scl_m = 1'b0;
   endtask

   task automatic sbyte(input logic [7:0] v, input int gidx, input int gsel, input int glen,
                        output logic ack);
      logic lb;
      for (int i = 7; i >= 0; i--) sbit(v[i], (7 - i == gidx) ? gsel : 0, glen, lb);
      sbit(1'b1, 0, 0, ack);
   endtask

   task automatic rbyte(input logic ack_out, output logic [7:0] v);
      logic lb;
      for (int i = 7; i >= 0; i--) begin
         sbit(1'b1, 0, 0, lb);
         v[i] = lb;
      end
      sbit(ack_out, 0, 0, lb);
   endtask

   task automatic t_reset();
      chk(!sda_oe && !irq && !rx_valid && !tx_req && !mst_ack_valid, "R10 reset outputs",
          {sda_oe, irq, rx_valid, tx_req, mst_ack_valid}, 0);
   endtask

   task automatic t_write_own();
      logic a; int i0 = irq_n; int r0 = rxv_n;
      bstart();
      sbyte({OWN, 1'b0}, -1, 0, 0, a);
      chk(a == 1'b0, "R3 own address ack", a, 0);
      chk(irq_n == i0 + 1 && !gc_hit, "R3 irq once, gc_hit clear", irq_n - i0, 1);
      sbyte(8'h3C, -1, 0, 0, a);
      chk(a == 1'b0, "R6 data ack", a, 0);
      sbyte(8'hC5, -1, 0, 0, a);
      bstop();
      chk(rxv_n == r0 + 2, "R6 rx_valid count", rxv_n - r0, 2);
      chk(rx_log[r0[3:0]] == 8'h3C && rx_log[r0[3:0] + 4'd1] == 8'hC5, "R6 rx bytes",
          {rx_log[r0[3:0]], rx_log[r0[3:0] + 4'd1]}, 16'h3CC5);
      chk(!sda_oe, "R9 released after stop", sda_oe, 0);
   endtask

   task automatic t_gcall();
      logic a; int i0 = irq_n; int r0 = rxv_n;
      bstart();
      sbyte(8'h00, -1, 0, 0, a);
      chk(a == 1'b0 && irq_n == i0 + 1, "R4 general call ack+irq", {a, irq_n[7:0] - i0[7:0]}, 1);
      chk(gc_hit, "R4 gc_hit set", gc_hit, 1);
      sbyte(8'h11, -1, 0, 0, a);
      bstop();
      chk(rxv_n == r0 + 1 && rx_log[r0[3:0]] == 8'h11, "R4 general call data",
          rx_log[r0[3:0]], 8'h11);
      i0 = irq_n;
      bstart();
      sbyte(8'h01, -1, 0, 0, a);
      bstop();
      chk(a == 1'b1 && irq_n == i0, "R4 general call read rejected", {a, irq_n[7:0] - i0[7:0]}, 9'h100);
   endtask

   task automatic t_miss();
      logic a, a2; int i0 = irq_n; int r0 = rxv_n;
      bstart();
      sbyte({7'h33, 1'b0}, -1, 0, 0, a);
      sbyte(8'h00, -1, 0, 0, a2);
      bstop();
      chk(a == 1'b1 && irq_n == i0, "R5 foreign address no ack/irq", {a, irq_n[7:0] - i0[7:0]}, 9'h100);
      chk(a2 == 1'b1 && rxv_n == r0, "R5 following byte ignored", rxv_n - r0, 0);
   endtask

   task automatic t_read();
      logic a; logic [7:0] v; logic [7:0] e1, e2; int t0 = txr_n; int m0 = mav_n;
      e1 = tx_data; e2 = tx_data + 8'h13;
      bstart();
      sbyte({OWN, 1'b1}, -1, 0, 0, a);
      chk(a == 1'b0 && xfer_rd, "R3 read address ack", a, 0);
      rbyte(1'b0, v);
      chk(v == e1, "R7 first byte", v, e1);
      chk(mav_n == m0 + 1 && !mst_nack, "R8 ack sampled", mst_nack, 0);
      rbyte(1'b1, v);
      chk(v == e2, "R7 second byte", v, e2);
      chk(mav_n == m0 + 2 && mst_nack, "R8 nack sampled", mst_nack, 1);
      rbyte(1'b1, v);
      chk(v == 8'hFF, "R8 line released after nack", v, 8'hFF);
      chk(txr_n == t0 + 2, "R8 no load after nack", txr_n - t0, 2);
      bstop();
      chk(viol == 0, "R7 sda_oe stable while SCL high", viol, 0);
   endtask

   task automatic t_restart();
      logic a, lb; logic [7:0] v; logic [7:0] e; int r0 = rxv_n;
      bstart();
      sbyte({OWN, 1'b0}, -1, 0, 0, a);
      sbit(1'b0, 0, 0, lb); sbit(1'b1, 0, 0, lb); sbit(1'b1, 0, 0, lb); sbit(1'b0, 0, 0, lb);
      bstart();
      e = tx_data;
      sbyte({OWN, 1'b1}, -1, 0, 0, a);
      chk(a == 1'b0, "R2 address after repeated start", a, 0);
      rbyte(1'b1, v);
      bstop();
      chk(v == e && rxv_n == r0, "R2 partial byte dropped", v, e);
   endtask

   task automatic t_spike();
      logic a; int i0 = irq_n; int r0 = rxv_n;
      bstart();
      sbyte({OWN, 1'b0}, 2, 1, 2, a);
      chk(a == 1'b0 && irq_n == i0 + 1, "R1 2-cycle SCL pulse ignored", a, 0);
      sbyte(8'h96, 0, 2, 2, a);
      bstop();
      chk(a == 1'b0 && rxv_n == r0 + 1 && rx_log[r0[3:0]] == 8'h96, "R1 2-cycle SDA pulse ignored",
          rx_log[r0[3:0]], 8'h96);
      i0 = irq_n;
      bstart();
      sbyte({OWN, 1'b0}, 2, 1, 3, a);
      bstop();
      chk(a == 1'b1 && irq_n == i0, "R1 3-cycle SCL pulse accepted", a, 1);
   endtask

   initial begin
      wt(5);
      t_reset();
      rst_n = 1'b1;
      wt(20);
      t_write_own();
      t_gcall();
      t_miss();
      t_read();
      t_restart();
      t_spike();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule